// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Configuration

This block is a supervision counter that advances on a prescaled tick strobe. It begins counting in the reset-request action as soon as the chip reset is released, so no software action is needed to arm it. Software services it over a small byte-wide bus that has two registers, chosen by one select line. The configuration register accepts a single write after reset. That write fixes the overflow action and the timeout interval. The service register restarts the count only when it receives one fixed key byte.

Any misuse forces an overflow at once. Misuse means a second configuration write, a wrong key, or a single-bit access to the service register. Each overflow produces a one-cycle pulse on one of three outputs: a reset request, a non-maskable interrupt request, or a request to move the CPU onto the internal oscillator. The last one is chosen when a reset-action overflow happens during the oscillation-settling window. If the configuration selects the stopped action, the watchdog stays idle and ignores all misuse.

Top module: `wdog_keyed`

## Requirements
- R1: After reset release the counter runs without any bus write. It uses the reset action and the default interval of 2^(RST_SEL+10) ticks. All three outputs are low during and right after reset.
- R2: The configuration register (bus_sel=0) stores the first byte written after reset and reads back that byte. Its fields are: bits [4:0] interval select; bits [6:5] action, where 00 is stopped, 01 is interrupt and 1x is reset; bit 7 is stored and has no effect. With RST_SEL=2 it reads 0x42 after reset.
- R3: A further configuration write while the watchdog is not stopped forces an overflow. The stored value and the interval stay unchanged.
- R4: With interval select n, the timeout is 2^(min(n,SEL_MAX)+10) ticks after the last restart. An accepted configuration write also restarts the count.
- R5: Writing 0xAC to the service register (bus_sel=1, bus_bit=0) clears the counter, so no overflow occurs while the key keeps arriving in time.
- R6: Writing any value other than 0xAC to the service register forces an overflow.
- R7: A service-register write with bus_bit=1 forces an overflow, whatever the data, including 0xAC.
- R8: The service register always reads 0x9A.
- R9: In the stopped action the counter does not run. Timeouts, wrong keys, bit accesses and extra configuration writes then produce no output pulse.
- R10: In the interrupt action an overflow pulses nmi_req. The counter clears and keeps running, so the next timeout follows one full interval later. osc_settle has no effect in this action.
- R11: In the reset action an overflow pulses clk_sw_req instead of rst_req while osc_settle is high.
- R12: Each overflow gives a pulse exactly one clock wide, on the clock after the edge that sampled the cause. At most one of the three outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled count strobe, one tick per high cycle |
| osc_settle | input | 1 | High during the oscillation-settling window after reset or standby exit |
| bus_wr | input | 1 | Byte write strobe |
| bus_sel | input | 1 | Register select: 0 configuration, 1 service |
| bus_bit | input | 1 | Marks the write as a single-bit read-modify-write access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| rst_req | output | 1 | One-cycle reset request |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| clk_sw_req | output | 1 | One-cycle request to switch the CPU clock to the internal oscillator |

## Verification
On every cycle, the embedded properties check four things: the outputs are mutually exclusive, no pulse follows a cycle in the stopped action, the configuration cannot change once it is locked, and the counter never exceeds the selected limit and is zero after any restart. Other behaviour needs the directed and random scenarios. These cover the exact timeout length for each interval, including the clamped one, and the fact that a steady stream of keys holds off overflow. They also cover the routing of wrong keys, bit accesses and double configuration writes to the correct output, the settling-window substitution, and the fixed read-back constant.

// File: rtl/wdk_pkg.sv
// Shared definitions for the keyed watchdog.
// Assumes byte-wide bus data; field layout of the configuration byte is fixed here.
package wdk_pkg;

    localparam logic [7:0] SERVICE_KEY = 8'hAC;
    localparam logic [7:0] SERVICE_RD  = 8'h9A;
    localparam int         BASE_EXP    = 10;

    typedef enum logic [1:0] {
        ACT_STOP = 2'b00,
        ACT_NMI  = 2'b01,
        ACT_RST  = 2'b10,
        ACT_RSTB = 2'b11
    } act_e;

    typedef struct packed {
        logic       spare;
        act_e       act;
        logic [4:0] sel;
    } mode_t;

endpackage

// File: rtl/wdk_mode.sv
// Configuration register with one-shot lock and misuse detection.
// Assumes write strobes are single-cycle qualified by the top; bit access
// applies to the service register only.
module wdk_mode #(
    parameter int RST_SEL = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mode,
    input  logic            wr_key,
    input  logic            bit_acc,
    input  logic [7:0]      wdata,
    output wdk_pkg::mode_t  mode_q,
    output logic            viol,
    output logic            restart
);
    import wdk_pkg::*;

    localparam mode_t RST_MODE = '{spare: 1'b0, act: ACT_RST, sel: 5'(RST_SEL)};

    logic locked_q;

    // Hold the configuration; only the first write after reset is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RST_MODE;
            locked_q <= 1'b0;
        end else if (wr_mode && !locked_q) begin
            mode_q   <= mode_t'(wdata);
            locked_q <= 1'b1;
        end
    end

    // Classify the current bus write as misuse or as a legal restart.
    always_comb begin
        viol    = (wr_mode && locked_q)
               || (wr_key && (bit_acc || (wdata != SERVICE_KEY)));
        restart = (wr_mode && !locked_q)
               || (wr_key && !bit_acc && (wdata == SERVICE_KEY));
    end

    // R2
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(mode_q));

    // R2
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> locked_q);

endmodule

// File: rtl/wdk_count.sv
// Interval counter: counts ticks up to 2^(sel+BASE_EXP) and flags expiry.
// Assumes sel is clamped here to SEL_MAX; self-clears on expiry.
module wdk_count #(
    parameter int SEL_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       clear,
    input  logic [4:0] sel,
    output logic       expire
);
    import wdk_pkg::*;

    localparam int CNT_W = SEL_MAX + BASE_EXP;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic [4:0]       sel_eff;
    logic [5:0]       shamt;

    // Clamp the interval select and derive the terminal count.
    always_comb begin
        sel_eff = (int'(sel) > SEL_MAX) ? 5'(SEL_MAX) : sel;
        shamt   = 6'(sel_eff) + 6'(BASE_EXP);
        lim_m1  = ({{(CNT_W-1){1'b0}}, 1'b1} << shamt) - 1'b1;
        expire  = run && tick && (cnt_q == lim_m1);
    end

    // Advance on each tick; restart on clear, expiry or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_m1);

endmodule

// File: rtl/wdk_evt.sv
// Overflow routing: turns an overflow event into one registered pulse on the
// output chosen by the action and the oscillator-settling window.
// Assumes the stopped action suppresses every event.
module wdk_evt (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  wdk_pkg::act_e act,
    input  logic         osc_settle,
    output logic         rst_req,
    output logic         nmi_req,
    output logic         clk_sw_req
);
    import wdk_pkg::*;

    logic fire;
    logic rst_act;

    // Decide whether the event counts and which action it takes.
    always_comb begin
        fire    = evt && (act != ACT_STOP);
        rst_act = (act == ACT_RST) || (act == ACT_RSTB);
    end

    // Register one-cycle request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req    <= 1'b0;
            nmi_req    <= 1'b0;
            clk_sw_req <= 1'b0;
        end else begin
            rst_req    <= fire && rst_act && !osc_settle;
            clk_sw_req <= fire && rst_act && osc_settle;
            nmi_req    <= fire && (act == ACT_NMI);
        end
    end

    // R12
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req, nmi_req, clk_sw_req}));

    // R9
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STOP) |=> !(rst_req || nmi_req || clk_sw_req));

endmodule

// File: rtl/wdog_keyed.sv
// Keyed watchdog top: write-once configuration, key-restarted counter,
// forced overflow on misuse, and routed request pulses.
// Assumes tick_en comes from an external prescaler, synchronous to clk.
module wdog_keyed #(
    parameter int SEL_MAX = 8,
    parameter int RST_SEL = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       osc_settle,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic       bus_bit,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       rst_req,
    output logic       nmi_req,
    output logic       clk_sw_req
);
    import wdk_pkg::*;

    logic  wr_mode;
    logic  wr_key;
    mode_t mode_q;
    logic  viol;
    logic  restart;
    logic  expire;
    logic  run;

    // Decode bus strobes, run state and read data.
    always_comb begin
        wr_mode   = bus_wr && !bus_sel;
        wr_key    = bus_wr && bus_sel;
        run       = (mode_q.act != ACT_STOP);
        bus_rdata = bus_sel ? SERVICE_RD : mode_q;
    end

    wdk_mode #(.RST_SEL(RST_SEL)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_mode),
        .wr_key  (wr_key),
        .bit_acc (bus_bit),
        .wdata   (bus_wdata),
        .mode_q  (mode_q),
        .viol    (viol),
        .restart (restart)
    );

    wdk_count #(.SEL_MAX(SEL_MAX)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .run    (run),
        .clear  (restart || viol),
        .sel    (mode_q.sel),
        .expire (expire)
    );

    wdk_evt u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (viol || expire),
        .act        (mode_q.act),
        .osc_settle (osc_settle),
        .rst_req    (rst_req),
        .nmi_req    (nmi_req),
        .clk_sw_req (clk_sw_req)
    );

endmodule

// File: tb/sim_wdog_keyed.sv
// Bench for wdog_keyed: directed corner cases mixed with seeded random keys
// and intervals; expected timing comes from the requirement formulas.
module sim_wdog_keyed;

    localparam int SMAX = 3;
    localparam int RSEL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       osc_settle = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_bit = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rst_req, nmi_req, clk_sw_req;

    int checks = 0;
    int errors = 0;

    wdog_keyed #(.SEL_MAX(SMAX), .RST_SEL(RSEL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .osc_settle(osc_settle),
        .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_bit(bus_bit),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .nmi_req(nmi_req), .clk_sw_req(clk_sw_req)
    );

    always #4 clk = ~clk;

    function automatic int span(int n);
        int e;
        e = (n > SMAX) ? SMAX : n;
        return 1 << (e + 10);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_bit = 1'b0; osc_settle = 1'b0; tick_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bwr(bit sel, logic [7:0] d, bit b);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d; bus_bit = b;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_bit = 1'b0;
    endtask

    task automatic wait_evt(int limit, output int n, output logic [2:0] w);
        n = 0; w = 3'b000;
        while (w == 3'b000 && n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            w = {rst_req, nmi_req, clk_sw_req};
        end
    endtask

    task automatic imm(logic [2:0] exp, string tag);
        @(negedge clk);
        chk({rst_req, nmi_req, clk_sw_req} == exp, tag,
            int'({rst_req, nmi_req, clk_sw_req}), int'(exp));
        @(negedge clk);
        chk({rst_req, nmi_req, clk_sw_req} == 3'b000, "R12 pulse width",
            int'({rst_req, nmi_req, clk_sw_req}), 0);
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        int len;
        int sel;
        int seed;
        logic [2:0] w;
        logic [7:0] v;

        seed = $urandom(32'h5eed);

        // R1 / R2 / R8: reset state and auto start
        do_reset();
        chk({rst_req, nmi_req, clk_sw_req} == 3'b000, "R1 reset outputs",
            int'({rst_req, nmi_req, clk_sw_req}), 0);
        bus_sel = 1'b1; #1;
        chk(bus_rdata == 8'h9A, "R8 service read", int'(bus_rdata), 8'h9A);
        bus_sel = 1'b0; #1;
        chk(bus_rdata == 8'h42, "R2 reset config read", int'(bus_rdata), 8'h42);
        wait_evt(span(RSEL) + 10, n, w);
        chk(n == span(RSEL), "R1 auto-start timeout", n, span(RSEL));
        chk(w == 3'b100, "R1 reset action", int'(w), 4);
        @(negedge clk);
        chk({rst_req, nmi_req, clk_sw_req} == 3'b000, "R12 timeout pulse width",
            int'({rst_req, nmi_req, clk_sw_req}), 0);

        // R5 / R4: keys in time hold off overflow, then timeout after last key
        do_reset();
        sel = $urandom_range(0, 1);
        len = span(sel);
        bwr(1'b0, 8'h40 | 8'(sel), 1'b0);
        for (int i = 0; i < 5; i++) begin
            wait_evt($urandom_range(10, len - 20), n, w);
            chk(w == 3'b000, "R5 no overflow while keyed", int'(w), 0);
            bwr(1'b1, 8'hAC, 1'b0);
        end
        bus_sel = 1'b1; #1;
        chk(bus_rdata == 8'h9A, "R8 read after key", int'(bus_rdata), 8'h9A);
        wait_evt(len + 10, n, w);
        chk(n == len, "R4 timeout after last key", n, len);
        chk(w == 3'b100, "R4 reset action on timeout", int'(w), 4);

        // R6: random wrong keys
        for (int i = 0; i < 6; i++) begin
            v = 8'($urandom_range(0, 255));
            if (v == 8'hAC) v = 8'h00;
            bwr(1'b1, v, 1'b0);
            imm(3'b100, "R6 wrong key");
        end
        bwr(1'b1, 8'h9A, 1'b0);
        imm(3'b100, "R6 read constant as key");

        // R7: bit access with the correct key
        bwr(1'b1, 8'hAC, 1'b1);
        imm(3'b100, "R7 bit access");

        // R3: double configuration write
        do_reset();
        bwr(1'b0, 8'h41, 1'b0);
        bwr(1'b0, 8'h63, 1'b0);
        imm(3'b100, "R3 second config write");
        bus_sel = 1'b0; #1;
        chk(bus_rdata == 8'h41, "R3 config unchanged", int'(bus_rdata), 8'h41);
        bwr(1'b1, 8'hAC, 1'b0);
        wait_evt(span(1) + 10, n, w);
        chk(n == span(1), "R3 interval unchanged", n, span(1));

        // R9: stopped action ignores everything
        do_reset();
        bwr(1'b0, 8'h00, 1'b0);
        wait_evt(6000, n, w);
        chk(w == 3'b000, "R9 no timeout when stopped", int'(w), 0);
        bwr(1'b1, 8'h55, 1'b0);
        bwr(1'b1, 8'hAC, 1'b1);
        bwr(1'b0, 8'h40, 1'b0);
        wait_evt(4, n, w);
        chk(w == 3'b000, "R9 misuse ignored when stopped", int'(w), 0);
        bus_sel = 1'b0; #1;
        chk(bus_rdata == 8'h00, "R9 config stays stopped", int'(bus_rdata), 0);

        // R10: interrupt action, periodic and forced
        do_reset();
        sel = $urandom_range(0, 1);
        len = span(sel);
        bwr(1'b0, 8'h20 | 8'(sel), 1'b0);
        wait_evt(len + 10, n, w);
        chk(n == len && w == 3'b010, "R10 first interrupt timeout", n, len);
        wait_evt(len + 10, n, w);
        chk(n == len && w == 3'b010, "R10 counter keeps running", n, len);
        bwr(1'b1, 8'h11, 1'b0);
        imm(3'b010, "R10 forced interrupt");
        osc_settle = 1'b1;
        bwr(1'b1, 8'h22, 1'b0);
        imm(3'b010, "R10 settle window has no effect");
        osc_settle = 1'b0;

        // R4: interval select clamped to the supported maximum
        do_reset();
        bwr(1'b0, 8'h5F, 1'b0);
        wait_evt(span(31) + 10, n, w);
        chk(n == span(31), "R4 clamped interval", n, span(31));
        bus_sel = 1'b0; #1;
        chk(bus_rdata == 8'h5F, "R2 stored select read", int'(bus_rdata), 8'h5F);

        // R11: settle window swaps reset for clock switch
        do_reset();
        osc_settle = 1'b1;
        bwr(1'b1, 8'h12, 1'b0);
        imm(3'b001, "R11 forced overflow in settle window");
        bwr(1'b0, 8'h40, 1'b0);
        wait_evt(span(0) + 10, n, w);
        chk(n == span(0) && w == 3'b001, "R11 timeout in settle window", int'(w), 1);
        osc_settle = 1'b0;

        finish_run();
    end

endmodule